// File: doc/BRIEF.md
# Ring-Routed Serial Register Access Controller

This block turns one parallel register-access request into a bit-serial transaction on one of seven serial rings. A requester presents a 13-bit address, a write flag and 64 bits of write data over a valid/ready handshake. The top three address bits name the ring. The remaining ten bits are a 4-bit satellite number followed by a 6-bit register number. Only these ten bits, with the write data on writes, are shifted out on the chosen ring's downlink.

After the downlink frame is sent, the controller watches only that ring's uplink for a reply. The reply carries a status bit and, on reads, 64 data bits. The result goes back to the requester over a second valid/ready handshake. A request that names ring 0 never touches any ring and completes at once with an error. A ring that stays silent too long is abandoned with an error. Only one request is handled at a time.

Top module: `ring_access_ctrl`

## Requirements
- R1: A request whose address bits [12:10] equal 0 drives no ring. On the next cycle it shows a response with `rsp_err`=1 and `rsp_rdata`=0.
- R2: `req_ready` is 1 only when no request is in flight. It drops on the cycle after a request is accepted and rises again only after the response handshake (`rsp_valid` and `rsp_ready` both 1 at a clock edge).
- R3: The downlink frame is sent one bit per cycle, and `dl_ctrl` of the ring is 1 for exactly the frame's bits. The frame is: a 1 start bit; the write bit (1 = write); address bits [9:0] MSB first; then, on writes only, `req_wdata` MSB first. A read frame is therefore 12 bits and a write frame 76 bits.
- R4: Ring n (1..7) uses bit n-1 of every per-ring bus. At most one `dl_ctrl` bit is ever 1, and it is the bit of the ring named by the request. Every `dl_data` bit whose `dl_ctrl` is 0 sits at the idle level 0.
- R5: An uplink reply begins in the first cycle after the downlink frame in which the ring's `ul_ctrl` and `ul_data` are both 1 (the start bit). The status bit follows in the next cycle, then, on reads only, 64 data bits MSB first, one per cycle.
- R6: A read completes with `rsp_rdata` equal to the 64 received data bits and `rsp_err` equal to the received status bit.
- R7: A write completes with `rsp_rdata`=0 and `rsp_err` equal to the received status bit.
- R8: If no start bit is seen within 256 cycles after the last downlink bit, the transaction ends with `rsp_err`=1 and `rsp_rdata`=0. The response becomes visible 256 cycles after the frame ends. A start bit seen within the window is accepted.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values.
- R10: Uplink activity on any ring other than the selected one has no effect: it neither starts a reply nor alters the returned data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Ring [12:10], satellite [9:6], register [5:0] |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 64 | Read data (0 on writes and errors) |
| rsp_err | output | 1 | Error: bad ring, timeout or satellite status |
| dl_data | output | 7 | Per-ring downlink data, bit n-1 for ring n |
| dl_ctrl | output | 7 | Per-ring downlink frame-active line |
| ul_data | input | 7 | Per-ring uplink data |
| ul_ctrl | input | 7 | Per-ring uplink control, 1 while a reply is on the line |

## Verification
The hardest situation to reach from the ports is a reply that lands near the end of the timeout window while the other rings' uplinks are busy. An idle ring gives no sign that the controller is still listening. The bench's satellite model therefore times its reply from the observed end of the downlink frame, with delays of 0, 200 and 254 cycles. It also has a silent mode, used to confirm the exact 256-cycle timeout latency. A noise switch holds the control and data lines of every unselected ring high. This makes a misrouted uplink select show up either as a spurious reply or as a timeout that fails to occur.

// File: rtl/ring_access_pkg.sv
package ring_access_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE,
    CTL_BUSY,
    CTL_RESP
  } ctl_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_WAIT,
    RX_RECV
  } rx_state_e;

  // downlink bits: start + write flag + address + optional data
  function automatic int dl_frame_len(logic wr, int aw, int dw);
    return 2 + aw + (wr ? dw : 0);
  endfunction

  // uplink bits after the start bit: status + optional read data
  function automatic int ul_frame_len(logic wr, int dw);
    return 1 + (wr ? 0 : dw);
  endfunction

endpackage

// File: rtl/ring_tx.sv
module ring_tx import ring_access_pkg::*; #(
  parameter int SER_AW = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wr,
  input  logic [SER_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              bit_o,
  output logic              active_o,
  output logic              last_o
);
  localparam int FRAME_W = 2 + SER_AW + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= {1'b1, wr, addr, (wr ? wdata : {DATA_W{1'b0}})};
      cnt <= CNT_W'(dl_frame_len(wr, SER_AW, DATA_W));
    end else if (cnt != '0) begin
      sh  <= {sh[FRAME_W-2:0], 1'b0};
      cnt <= cnt - 1'b1;
    end
  end

  assign bit_o    = sh[FRAME_W-1];
  assign active_o = (cnt != '0);
  assign last_o   = (cnt == CNT_W'(1));
endmodule

// File: rtl/ring_rx.sv
module ring_rx import ring_access_pkg::*; #(
  parameter int DATA_W  = 64,
  parameter int TIMEOUT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              wr,
  input  logic              ul_data,
  input  logic              ul_ctrl,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              timeout_o
);
  localparam int TCNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam int LEN_W  = $clog2(DATA_W + 2);

  rx_state_e         st;
  logic [TCNT_W-1:0] tcnt;
  logic [LEN_W-1:0]  left;
  logic [DATA_W-1:0] sh;
  logic [DATA_W:0]   shifted;
  logic              start_evt;
  logic              recv_last;

  assign shifted   = {sh, ul_data};
  assign start_evt = (st == RX_WAIT) && ul_ctrl && ul_data;
  assign timeout_o = (st == RX_WAIT) && !start_evt && (tcnt == TCNT_W'(TIMEOUT - 1));
  assign recv_last = (st == RX_RECV) && (left == LEN_W'(1));
  assign done_o    = timeout_o || recv_last;
  assign rdata_o   = (timeout_o || wr) ? '0 : shifted[DATA_W-1:0];
  assign err_o     = timeout_o ? 1'b1 : (wr ? shifted[0] : shifted[DATA_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      left <= '0;
      sh   <= '0;
    end else begin
      case (st)
        RX_IDLE: if (arm) begin
          st   <= RX_WAIT;
          tcnt <= '0;
        end
        RX_WAIT: begin
          if (start_evt) begin
            st   <= RX_RECV;
            left <= LEN_W'(ul_frame_len(wr, DATA_W));
            sh   <= '0;
          end else if (timeout_o) begin
            st <= RX_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_RECV: begin
          sh   <= shifted[DATA_W-1:0];
          left <= left - 1'b1;
          if (recv_last) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_port_mux.sv
module ring_port_mux #(
  parameter int RING_W = 3,
  parameter int NRING  = 7
) (
  input  logic [RING_W-1:0] sel,
  input  logic              tx_bit,
  input  logic              tx_active,
  input  logic [NRING-1:0]  ul_data,
  input  logic [NRING-1:0]  ul_ctrl,
  output logic [NRING-1:0]  dl_data,
  output logic [NRING-1:0]  dl_ctrl,
  output logic              sel_ul_data,
  output logic              sel_ul_ctrl
);
  logic [NRING-1:0] hit;

  for (genvar i = 0; i < NRING; i++) begin : g_ring
    assign hit[i]     = (sel == RING_W'(i + 1));
    assign dl_ctrl[i] = hit[i] && tx_active;
    assign dl_data[i] = hit[i] && tx_active && tx_bit;
  end

  assign sel_ul_data = |(ul_data & hit);
  assign sel_ul_ctrl = |(ul_ctrl & hit);
endmodule

// File: rtl/ring_access_ctrl.sv
module ring_access_ctrl import ring_access_pkg::*; #(
  parameter int RING_W  = 3,
  parameter int SAT_W   = 4,
  parameter int REG_W   = 6,
  parameter int DATA_W  = 64,
  parameter int TIMEOUT = 256,
  localparam int SER_AW = SAT_W + REG_W,
  localparam int ADDR_W = RING_W + SER_AW,
  localparam int NRING  = (1 << RING_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [NRING-1:0]  dl_data,
  output logic [NRING-1:0]  dl_ctrl,
  input  logic [NRING-1:0]  ul_data,
  input  logic [NRING-1:0]  ul_ctrl
);
  ctl_state_e        st;
  logic [RING_W-1:0] sel_q;
  logic              wr_q;
  logic [RING_W-1:0] req_ring;
  logic              accept, accept_bad, accept_ok;
  logic              tx_bit, tx_active, tx_last;
  logic              up_data, up_ctrl;
  logic              rx_done, rx_err, timeout_evt;
  logic [DATA_W-1:0] rx_rdata;

  assign req_ring   = req_addr[ADDR_W-1 -: RING_W];
  assign req_ready  = (st == CTL_IDLE);
  assign rsp_valid  = (st == CTL_RESP);
  assign accept     = req_valid && req_ready;
  assign accept_bad = accept && (req_ring == '0);
  assign accept_ok  = accept && (req_ring != '0);

  ring_tx #(.SER_AW(SER_AW), .DATA_W(DATA_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .load(accept_ok), .wr(req_write),
    .addr(req_addr[SER_AW-1:0]), .wdata(req_wdata),
    .bit_o(tx_bit), .active_o(tx_active), .last_o(tx_last)
  );

  ring_port_mux #(.RING_W(RING_W), .NRING(NRING)) mux_i (
    .sel(sel_q), .tx_bit(tx_bit), .tx_active(tx_active),
    .ul_data(ul_data), .ul_ctrl(ul_ctrl),
    .dl_data(dl_data), .dl_ctrl(dl_ctrl),
    .sel_ul_data(up_data), .sel_ul_ctrl(up_ctrl)
  );

  ring_rx #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) rx_i (
    .clk(clk), .rst_n(rst_n), .arm(tx_last), .wr(wr_q),
    .ul_data(up_data), .ul_ctrl(up_ctrl),
    .done_o(rx_done), .err_o(rx_err), .rdata_o(rx_rdata),
    .timeout_o(timeout_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= CTL_IDLE;
      sel_q     <= '0;
      wr_q      <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (st)
        CTL_IDLE: begin
          if (accept_bad) begin
            st        <= CTL_RESP;
            rsp_rdata <= '0;
            rsp_err   <= 1'b1;
          end else if (accept_ok) begin
            st    <= CTL_BUSY;
            sel_q <= req_ring;
            wr_q  <= req_write;
          end
        end
        CTL_BUSY: if (rx_done) begin
          st        <= CTL_RESP;
          rsp_rdata <= rx_rdata;
          rsp_err   <= rx_err;
        end
        CTL_RESP: if (rsp_ready) begin
          st    <= CTL_IDLE;
          sel_q <= '0;
        end
        default: st <= CTL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_access_chk.sv
module ring_access_chk #(
  parameter int RING_W = 3,
  parameter int NRING  = 7,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [RING_W-1:0] req_ring,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic [NRING-1:0]  dl_data,
  input logic [NRING-1:0]  dl_ctrl,
  input logic              timeout_evt
);
  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R4
  one_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dl_ctrl));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_data & ~dl_ctrl) == '0);

  // R1
  ring0_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_ring == '0) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || rsp_valid) |-> (dl_ctrl == '0));

  // R8
  timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (rsp_valid && rsp_err && rsp_rdata == '0));
endmodule

bind ring_access_ctrl ring_access_chk #(.RING_W(RING_W), .NRING(NRING), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ring(req_ring), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .dl_data(dl_data),
  .dl_ctrl(dl_ctrl), .timeout_evt(timeout_evt)
);

// File: tb/ring_access_ctrl_test.sv
module ring_access_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [12:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [NR-1:0] dl_data, dl_ctrl, ul_data, ul_ctrl;
  logic [NR-1:0] sat_d = '0, sat_c = '0, noise = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ul_data = sat_d | noise;
  assign ul_ctrl = sat_c | noise;

  ring_access_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .dl_data(dl_data), .dl_ctrl(dl_ctrl),
    .ul_data(ul_data), .ul_ctrl(ul_ctrl)
  );

  typedef struct { logic [63:0] rdata; logic err; int latency; string tag; } exp_t;
  exp_t expq[$];

  int checks = 0, fails = 0, frames_seen = 0, since_end = 0;
  // satellite model settings
  int exp_ring = 0, exp_len = 0, sat_delay = 0;
  bit sat_respond = 0, sat_wr = 0, sat_status = 0;
  logic [63:0] sat_rdata = '0;
  logic [127:0] exp_frame = '0, cap = '0;
  int ncap = 0, rleft = 0, rwait = 0;
  bit rpend = 0, bad4 = 0, prev_valid = 0;
  logic [65:0] rvec = '0;

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // satellite model and response monitor, both on the falling edge
  always @(negedge clk) begin
    logic [NR-1:0] mask;
    mask = (exp_ring >= 1 && exp_ring <= NR) ? NR'(1 << (exp_ring - 1)) : '0;
    since_end++;
    if ((dl_data & ~dl_ctrl) != '0) bad4 = 1;
    if (dl_ctrl != '0) begin
      if (dl_ctrl != mask) bad4 = 1;
      cap = {cap[126:0], |(dl_data & mask)};
      ncap++;
    end else if (ncap > 0) begin
      // R3 frame length and content
      check(ncap == exp_len && cap == exp_frame, "R3 downlink frame", cap, exp_frame);
      // R4 only the named ring, others idle
      check(!bad4, "R4 ring isolation", 128'(dl_ctrl), 128'(mask));
      frames_seen++;
      since_end = 0;
      ncap = 0; cap = '0; bad4 = 0;
      if (sat_respond) begin
        rpend = 1; rwait = sat_delay;
        rvec  = {1'b1, sat_status, (sat_wr ? 64'h0 : sat_rdata)};
        rleft = sat_wr ? 2 : 66;
      end
    end
    // R5 reply: start, status, data MSB first
    if (rpend) begin
      if (rwait > 0) rwait--;
      else if (rleft > 0) begin
        sat_c = mask;
        sat_d = rvec[65] ? mask : '0;
        rvec  = {rvec[64:0], 1'b0};
        rleft--;
      end else begin
        sat_c = '0; sat_d = '0; rpend = 0;
      end
    end
    // response monitor
    if (rsp_valid) begin
      if (expq.size() == 0) check(0, "R6 unexpected response", 128'(rsp_rdata), 0);
      else begin
        check(rsp_rdata == expq[0].rdata && rsp_err == expq[0].err,
              expq[0].tag, {63'h0, rsp_err, rsp_rdata}, {63'h0, expq[0].err, expq[0].rdata});
        if (!prev_valid && expq[0].latency >= 0)
          check(since_end == expq[0].latency, "R8 timeout latency", 128'(since_end), 128'(expq[0].latency));
        if (rsp_ready) void'(expq.pop_front());
      end
    end
    prev_valid = rsp_valid && !rsp_ready;
  end

  task automatic do_req(bit wr, logic [2:0] ring, logic [9:0] low, logic [63:0] wd,
                        bit respond, int delay, bit status, logic [63:0] rd,
                        logic [63:0] e_rdata, bit e_err, int lat, string tag);
    int frames0;
    exp_t e;
    exp_ring = ring; sat_wr = wr; sat_respond = respond; sat_delay = delay;
    sat_status = status; sat_rdata = rd;
    exp_len   = wr ? 76 : 12;
    exp_frame = wr ? 128'({2'b11, low, wd}) : 128'({2'b10, low});
    e.rdata = e_rdata; e.err = e_err; e.latency = lat; e.tag = tag;
    expq.push_back(e);
    frames0 = frames_seen;
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = {ring, low}; req_wdata = wd;
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
    // R2 ready low once a request is taken
    check(req_ready == 0, "R2 ready low after accept", 128'(req_ready), 0);
    if (ring == 0)
      check(rsp_valid == 1 && rsp_err == 1, "R1 immediate error", 128'({rsp_valid, rsp_err}), 128'(3));
    while (expq.size() != 0) begin
      if (rsp_valid) check(req_ready == 0, "R2 ready low while response pending", 128'(req_ready), 0);
      @(posedge clk); #1;
    end
    check(req_ready == 1, "R2 ready after handshake", 128'(req_ready), 1);
    if (ring == 0)
      check(frames_seen == frames0, "R1 no ring driven", 128'(frames_seen), 128'(frames0));
    else
      check(frames_seen == frames0 + 1, "R3 one frame per request", 128'(frames_seen), 128'(frames0 + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R4 reset: lines idle, ready high, no response
    check(req_ready == 1 && rsp_valid == 0 && dl_ctrl == 0 && dl_data == 0,
          "R4 reset state", 128'({req_ready, rsp_valid, dl_ctrl, dl_data}), 128'({2'b10, 14'h0}));

    do_req(0, 3'd3, {4'h5, 6'h21}, 64'h0, 1, 3, 0, 64'hDEADBEEF_01234567,
           64'hDEADBEEF_01234567, 0, -1, "R5 R6 read ring 3");
    do_req(1, 3'd7, {4'hA, 6'h3F}, 64'hA5A5_0F0F_1234_8001, 1, 0, 0, 64'h0,
           64'h0, 0, -1, "R7 write ring 7");
    do_req(1, 3'd1, {4'h0, 6'h01}, 64'hFFFF_0000_FFFF_0000, 1, 2, 1, 64'h0,
           64'h0, 1, -1, "R7 write status error");
    do_req(0, 3'd5, {4'hF, 6'h00}, 64'h0, 1, 200, 1, 64'h8000_0000_0000_0001,
           64'h8000_0000_0000_0001, 1, -1, "R6 read status error delay 200");
    do_req(0, 3'd0, {4'h3, 6'h12}, 64'h0, 0, 0, 0, 64'h0,
           64'h0, 1, -1, "R1 ring 0 read");
    do_req(1, 3'd0, {4'h1, 6'h02}, 64'h1234, 0, 0, 0, 64'h0,
           64'h0, 1, -1, "R1 ring 0 write");
    do_req(0, 3'd2, {4'h7, 6'h15}, 64'h0, 0, 0, 0, 64'h0,
           64'h0, 1, 256, "R8 silent ring timeout");
    do_req(0, 3'd6, {4'h2, 6'h2A}, 64'h0, 1, 254, 0, 64'h0123_4567_89AB_CDEF,
           64'h0123_4567_89AB_CDEF, 0, -1, "R8 late reply inside window");

    noise = 7'b1110111;  // every ring except ring 4
    do_req(0, 3'd4, {4'h9, 6'h0C}, 64'h0, 1, 5, 0, 64'hCAFE_F00D_0000_FFFF,
           64'hCAFE_F00D_0000_FFFF, 0, -1, "R10 noise on other rings");
    noise = 7'b1011111;  // every ring except ring 6
    do_req(0, 3'd6, {4'h4, 6'h30}, 64'h0, 0, 0, 0, 64'h0,
           64'h0, 1, 256, "R10 noise does not start a reply");
    noise = '0;

    rsp_ready = 0;
    fork
      do_req(0, 3'd2, {4'hC, 6'h0F}, 64'h0, 1, 1, 0, 64'h5555_AAAA_3333_CCCC,
             64'h5555_AAAA_3333_CCCC, 0, -1, "R9 held response");
      begin
        while (!rsp_valid) begin @(posedge clk); #1; end
        repeat (6) @(posedge clk);
        #1 rsp_ready = 1;
      end
    join

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule